// File: doc/BRIEF.md
# Gated Programmable-Duty Clock Divider

This block produces a divided clock from its input clock. Software programs two fields through a small write port. The divide field sets the ratio. A value of zero stops the output and holds it low. Any nonzero value N gives an output period of N+1 input cycles. The high-time field sets how many cycles of each period the output is high. A value h gives h+1 high cycles, so the duty cycle is (1+h)/(1+N).

A build-time parameter selects a variant with no high-time field. In that variant the duty cycle is fixed near one half. New settings are held in the field registers. They move into the running counter only at a period boundary, so a write never shortens the current period or its high phase. A gated block treats every cycle as a boundary, so enabling it starts a new period on the next edge. The output is driven straight from a flop.

Top module: `gated_duty_clkdiv`

## Requirements
- R1: After synchronous reset, `clk_out` is low and both fields read back as 0.
- R2: While the active divide value is 0 the output stays low, whatever the high-time field holds.
- R3: With a divide field of N ≥ 1, the output period is exactly N+1 input clock cycles.
- R4: Each period starts with its high phase. With high-time h ≤ N, the output is high for the first h+1 cycles of the period and low for the rest.
- R5: A high-time value greater than N is treated as N, so the output stays high for the whole period.
- R6: With `HAS_HIGH` = 0 the high-time field is absent. The output is high for floor(N/2)+1 cycles of each period, so on an odd ratio the high phase is the larger part.
- R7: Field writes made during a period do not change that period. They take effect from the next period boundary.
- R8: Writing 0 to the divide field while running lets the current period finish, and the output then stays low.
- R9: `wr_sel`/`rd_sel` value 0 selects the divide field and 1 selects the high-time field. A read returns the stored field value, and the high-time field reads 0 when `HAS_HIGH` = 0.
- R10: N = 1 gives the smallest ratio of 2, and N = 2^DIV_W−1 gives the largest ratio of 2^DIV_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 1 | Write target: 0 divide field, 1 high-time field |
| wr_data | input | DIV_W | Value to write |
| rd_sel | input | 1 | Read target: 0 divide field, 1 high-time field |
| rd_data | output | DIV_W | Selected field value (combinational) |
| clk_out | output | 1 | Divided, duty-programmed output clock |

## Verification
A write strobed at one edge reaches the field register at that edge. A gated block then loads the new setting at the following edge, so `clk_out` shows the first high cycle after two edges. After that, each later period cycle is due one edge apart. Read-back is combinational and is checked before the next edge. The bench drives inputs on falling edges and samples `clk_out` once per falling edge. It tracks the period position as an index that starts at 0 on the first sample after enabling, so each check compares against the expected level for that index. Mid-period write scenarios count the cycles spent in the write task so the index stays aligned.

// File: rtl/clkdiv_pkg.sv
// Shared definitions for the gated programmable-duty clock divider.
// Assumes: field selection is a single bit on both read and write ports.
package clkdiv_pkg;

    // Field selector encoding used by the write and read ports (R9)
    typedef enum logic {
        SEL_DIV  = 1'b0,
        SEL_HIGH = 1'b1
    } field_sel_e;

endpackage

// File: rtl/clkdiv_regs.sv
// Field register file: stores the divide field and, when HAS_HIGH is set,
// the high-time field. Reads are combinational.
// Assumes: one write per cycle; the high-time value is stored raw (no clamping).
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter bit HAS_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [DIV_W-1:0] rd_data,
    output logic [DIV_W-1:0] div_q,
    output logic [DIV_W-1:0] hi_q
);

    // Divide field storage; zero means gated
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (wr_en && field_sel_e'(wr_sel) == SEL_DIV)
            div_q <= wr_data;
    end

    generate
        if (HAS_HIGH) begin : g_high_field
            // High-time field storage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hi_q <= '0;
                else if (wr_en && field_sel_e'(wr_sel) == SEL_HIGH)
                    hi_q <= wr_data;
            end
        end else begin : g_no_high_field
            assign hi_q = '0;
        end
    endgenerate

    // Read multiplexer
    always_comb begin
        rd_data = (field_sel_e'(rd_sel) == SEL_DIV) ? div_q : hi_q;
    end

endmodule

// File: rtl/clkdiv_hi_map.sv
// Maps the stored fields to the effective high-time count that the period
// engine latches. With a high-time field the value is clamped to the divide
// value. Without one it is half the divide value, rounded down.
// Assumes: purely combinational; the engine samples it only at boundaries.
module clkdiv_hi_map #(
    parameter int DIV_W    = 4,
    parameter bit HAS_HIGH = 1'b1
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic [DIV_W-1:0] hi_val,
    output logic [DIV_W-1:0] eff_hi
);

    generate
        if (HAS_HIGH) begin : g_clamp
            // Clamp a programmed high time that exceeds the period (R5)
            always_comb begin
                eff_hi = (hi_val > div_val) ? div_val : hi_val;
            end
        end else begin : g_half
            // Fixed near-half duty; larger half is the high phase (R6)
            always_comb begin
                eff_hi = div_val >> 1;
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_engine.sv
// Period engine: counts 0..N within each period, latches new settings only
// at a period boundary, and drives the registered output clock.
// Assumes: cfg_hi is already no greater than cfg_div; a zero active divide
// value means gated, and every gated cycle counts as a boundary.
module clkdiv_engine #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [DIV_W-1:0] cfg_hi,
    output logic             clk_out
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] act_hi;
    logic [DIV_W-1:0] cnt_inc;
    logic             boundary;
    logic             out_q;

    // Boundary detect: gated, or last cycle of the running period
    always_comb begin
        boundary = (act_div == '0) || (cnt == act_div);
        cnt_inc  = cnt + 1'b1;
    end

    // Counter, settings latch and registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_div <= '0;
            act_hi  <= '0;
            out_q   <= 1'b0;
        end else if (boundary) begin
            cnt     <= '0;
            act_div <= cfg_div;
            act_hi  <= cfg_hi;
            out_q   <= (cfg_div != '0);
        end else begin
            cnt     <= cnt_inc;
            out_q   <= (cnt_inc <= act_hi);
        end
    end

    assign clk_out = out_q;

    // R2
    gated_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0 && cfg_div == '0) |=> !clk_out);

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_div);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> (cnt == $past(cnt) + 1'b1));

    // R4
    period_starts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && cfg_div != '0) |=> clk_out);

    // R4
    high_within_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> (act_div != '0 && cnt <= act_hi));

    // R5
    hi_not_above_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_hi <= act_div);

    // R7
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(act_div) && $stable(act_hi)));

endmodule

// File: rtl/gated_duty_clkdiv.sv
// Top of the gated programmable-duty clock divider: field registers, the
// high-time mapping (selected by HAS_HIGH) and the period engine.
// Assumes: all logic runs in the input clock domain; reset is synchronous.
module gated_duty_clkdiv #(
    parameter int DIV_W    = 4,
    parameter bit HAS_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [DIV_W-1:0] rd_data,
    output logic             clk_out
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] hi_q;
    logic [DIV_W-1:0] eff_hi;

    clkdiv_regs #(
        .DIV_W    (DIV_W),
        .HAS_HIGH (HAS_HIGH)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .div_q   (div_q),
        .hi_q    (hi_q)
    );

    clkdiv_hi_map #(
        .DIV_W    (DIV_W),
        .HAS_HIGH (HAS_HIGH)
    ) hi_map_i (
        .div_val (div_q),
        .hi_val  (hi_q),
        .eff_hi  (eff_hi)
    );

    clkdiv_engine #(
        .DIV_W (DIV_W)
    ) engine_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_div (div_q),
        .cfg_hi  (eff_hi),
        .clk_out (clk_out)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!clk_out && div_q == '0));

endmodule

// File: tb/gated_duty_clkdiv_tb.sv
// Directed bench: one task per scenario. A full-featured instance and a
// fixed half-duty instance share the write bus.
module gated_duty_clkdiv_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 4;
    localparam int MAX_N      = (1 << DIV_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic             wr_sel;
    logic [DIV_W-1:0] wr_data;
    logic             rd_sel;
    logic [DIV_W-1:0] rd_main;
    logic [DIV_W-1:0] rd_half;
    logic             out_main;
    logic             out_half;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_duty_clkdiv #(.DIV_W(DIV_W), .HAS_HIGH(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_main), .clk_out(out_main)
    );

    gated_duty_clkdiv #(.DIV_W(DIV_W), .HAS_HIGH(1'b0)) dut_half_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_half), .clk_out(out_half)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Caller sits at a falling edge; returns one falling edge later
    task automatic write_field(input logic sel, input int val);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = val[DIV_W-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic start(input int n, input int h);
        write_field(1'b1, h);
        write_field(1'b0, n);
    endtask

    task automatic drain();
        write_field(1'b0, 0);
        repeat (2 * MAX_N + 4) @(negedge clk);
        check("R8 drained main", out_main, 0);
        check("R8 drained half", out_half, 0);
    endtask

    // Samples whole periods starting at index 0
    task automatic check_pattern(input int n, input int h, input int periods, input string req);
        int hm = (h > n) ? n : h;
        int hh = n >> 1;
        for (int p = 0; p < periods; p++) begin
            for (int c = 0; c <= n; c++) begin
                @(negedge clk);
                check({req, " main"}, out_main, (c <= hm) ? 1 : 0);
                check({req, " half R6"}, out_half, (c <= hh) ? 1 : 0);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out main", out_main, 0);
        check("R1 out half", out_half, 0);
        rd_sel = 1'b0; #1;
        check("R1 div read", rd_main, 0);
        rd_sel = 1'b1; #1;
        check("R1 high read", rd_main, 0);
        @(negedge clk);
    endtask

    task automatic t_gated();
        write_field(1'b1, 5);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R2 gated main", out_main, 0);
            check("R2 gated half", out_half, 0);
        end
    endtask

    task automatic t_basic();
        start(3, 1);
        check_pattern(3, 1, 2, "R3 R4 N=3 h=1");
        drain();
        start(4, 0);
        check_pattern(4, 0, 2, "R3 R4 odd N=4 h=0");
        drain();
    endtask

    task automatic t_full_high();
        start(2, 7);
        check_pattern(2, 7, 3, "R5 h>N");
        drain();
    endtask

    task automatic t_extremes();
        start(1, 0);
        check_pattern(1, 0, 3, "R10 min ratio");
        drain();
        start(MAX_N, 5);
        check_pattern(MAX_N, 5, 2, "R10 max ratio");
        drain();
    endtask

    task automatic t_reload();
        start(3, 1);
        @(negedge clk);
        check("R7 idx0", out_main, 1);
        write_field(1'b1, 3);
        check("R7 idx1", out_main, 1);
        write_field(1'b0, 5);
        check("R7 idx2 old high time", out_main, 0);
        @(negedge clk);
        check("R7 idx3 old period", out_main, 0);
        for (int c = 0; c <= 5; c++) begin
            @(negedge clk);
            check("R7 new period", out_main, (c <= 3) ? 1 : 0);
        end
    endtask

    task automatic t_disable();
        // Arrives at index 5 of an N=5 period; next sample is index 0
        @(negedge clk);
        check("R8 idx0", out_main, 1);
        write_field(1'b0, 0);
        for (int c = 1; c <= 5; c++) begin
            check("R8 finishing period", out_main, (c <= 3) ? 1 : 0);
            @(negedge clk);
        end
        for (int i = 0; i < 10; i++) begin
            check("R8 stopped", out_main, 0);
            @(negedge clk);
        end
        rd_sel = 1'b0; #1;
        check("R8 R9 div reads 0", rd_main, 0);
    endtask

    task automatic t_readback();
        start(6, 9);
        rd_sel = 1'b0; #1;
        check("R9 div main", rd_main, 6);
        check("R9 div half", rd_half, 6);
        rd_sel = 1'b1; #1;
        check("R9 high main", rd_main, 9);
        check("R9 high half", rd_half, 0);
        @(negedge clk);
        drain();
    endtask

    initial begin
        t_reset();
        t_gated();
        t_basic();
        t_full_high();
        t_extremes();
        t_reload();
        t_disable();
        t_readback();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule